// File: doc/BRIEF.md
# Phase-Synchronized PWM Timer

This block is a free-running pulse-width timer meant to be chained with identical copies so that several outputs share one period while holding fixed phase offsets from each other. A time-base counter runs from zero up to a programmed period value and then wraps. The output pin is driven from a comparison of the counter against a duty (compare) value, and a polarity select can invert it. The period and compare values pass through shadow registers, so a change made while the timer runs takes effect only at the next wrap.

To build a multiphase interleaved converter drive, one instance acts as master. It ignores its sync input and emits a one-clock sync pulse each time its counter reaches the period. Each downstream instance accepts the sync pulse, loads its counter with its own phase value, and relays the pulse onward one clock later. Because every hop adds one clock, the phase offset of hop h (1 for the first follower) is (P + 1 - phase + h) mod (P + 1) clocks, where P is the period value. With P = 11, phases of 9 and 6 place the two followers at one third and two thirds of the cycle.

Top module: `phsync_pwm_timer`

## Requirements
- R1: While running and not sync-loaded, the counter advances by one per clock from 0 up to the active period value P and then returns to 0, so one cycle lasts P + 1 clocks (P of at least 1).
- R2: With polarity select 0, `pwm_o` is registered from the counter: it is high in the clock after the counter holds a value below the active compare value C, and low otherwise; C = 0 keeps it low all cycle and C > P keeps it high all cycle, so it is high for C of every P + 1 clocks when C is at most P.
- R3: With polarity select 1 the output is the inverse of R2, high for P + 1 - C clocks per cycle.
- R4: Sync-out select value 1 gives a pulse on `sync_out_o` exactly one clock wide, in the clock after the counter equals the period value, once per cycle.
- R5: Sync-out select value 2 copies `sync_in_i` onto `sync_out_o` delayed by exactly one clock.
- R6: Sync-out select values 0 and 3 hold `sync_out_o` low whatever the counter and `sync_in_i` do.
- R7: When running with `sync_en_i` high, a high `sync_in_i` loads the counter with `phase_i` at the next edge, taking priority over the increment and the wrap.
- R8: With `sync_en_i` low, `sync_in_i` has no effect on the counter.
- R9: With `run_i` low the counter holds its value, `pwm_o` stays constant and no period pulse is produced; raising `run_i` resumes counting from the held value.
- R10: While running, new `period_i` and `compare_i` values are taken into the active registers only at the edge where the counter wraps; while stopped they are taken at every edge.
- R11: Reset clears the counter, `pwm_o` and `sync_out_o`.
- R12: A master (select 1, sync disabled) and two relaying followers with period 11 and phases 9 and 6 produce output rising edges offset by 4 and 8 clocks from the master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_i | input | 1 | 1 lets the counter run, 0 freezes it |
| period_i | input | CNT_W | Period value, goes through the shadow register |
| compare_i | input | CNT_W | Duty compare value, goes through the shadow register |
| phase_i | input | CNT_W | Value loaded into the counter on an accepted sync |
| pol_low_i | input | 1 | 0 active-high output, 1 active-low output |
| sync_en_i | input | 1 | 1 lets `sync_in_i` load the phase value |
| sync_sel_i | input | 2 | Sync-out source: 0 off, 1 period match, 2 relay of sync-in, 3 off |
| sync_in_i | input | 1 | Incoming sync pulse |
| sync_out_o | output | 1 | Registered outgoing sync pulse |
| pwm_o | output | 1 | Registered PWM output |

## Verification
The bound checker watches, on every clock, the counter's increment and wrap, the phase load and its precedence, freezing while stopped, the shadow registers holding still mid-cycle, the one-clock width of the period pulse and the exact one-clock relay and silence of the sync output under each select value. Duty ratios for both polarities, the compare extremes, the cycle length after a period change and the point where a new compare value first shows at the pin are only visible over whole cycles, so the directed scenarios measure them at the output. The phase spacing of a three-instance chain, which depends on the hop delays adding up, is shown only by the bench's chain scenario.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  // Sync-out source encoding on sync_sel_i
  typedef enum logic [1:0] {
    SYNC_OFF   = 2'd0,
    SYNC_PRD   = 2'd1,
    SYNC_RELAY = 2'd2,
    SYNC_OFF_B = 2'd3
  } sync_src_e;

endpackage

// File: rtl/pwmt_shadow.sv
// Active period and compare registers; inputs act as the shadow side.
module pwmt_shadow #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             wrap,
  input  logic [CNT_W-1:0] prd_in,
  input  logic [CNT_W-1:0] cmp_in,
  output logic [CNT_W-1:0] prd_act,
  output logic [CNT_W-1:0] cmp_act
);

  logic take;

  // R10: transfer only at the wrap while running, freely while stopped
  assign take = !run || wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      prd_act <= '0;
      cmp_act <= '0;
    end else if (take) begin
      prd_act <= prd_in;
      cmp_act <= cmp_in;
    end
  end

endmodule

// File: rtl/pwmt_timebase.sv
// Up-counter with wrap at the active period and phase load on sync.
module pwmt_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load_phase,
  input  logic [CNT_W-1:0] phase,
  input  logic [CNT_W-1:0] prd_act,
  output logic [CNT_W-1:0] cnt,
  output logic             at_prd,
  output logic             wrap
);

  logic at_or_past;

  assign at_or_past = (cnt >= prd_act);
  assign at_prd     = (cnt == prd_act);
  assign wrap       = run && at_or_past;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (run) begin
      if (load_phase) begin
        cnt <= phase;               // R7: sync load wins over increment
      end else if (at_or_past) begin
        cnt <= '0;                  // R1: wrap
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwmt_outstage.sv
// Registered PWM pin and sync-out routing.
module pwmt_outstage
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_act,
  input  logic             at_prd,
  input  logic             pol_low,
  input  logic [1:0]       sync_sel,
  input  logic             sync_in,
  output logic             pwm,
  output logic             sync_out
);

  logic      active;
  logic      pwm_d;
  logic      sync_d;
  sync_src_e src;

  assign src    = sync_src_e'(sync_sel);
  assign active = (cnt < cmp_act);
  assign pwm_d  = active ^ pol_low;

  always_comb begin
    case (src)
      SYNC_PRD:   sync_d = run && at_prd;
      SYNC_RELAY: sync_d = sync_in;
      default:    sync_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm      <= 1'b0;
      sync_out <= 1'b0;
    end else begin
      pwm      <= pwm_d;
      sync_out <= sync_d;
    end
  end

endmodule

// File: rtl/phsync_pwm_timer.sv
module phsync_pwm_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] compare_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic             pol_low_i,
  input  logic             sync_en_i,
  input  logic [1:0]       sync_sel_i,
  input  logic             sync_in_i,
  output logic             sync_out_o,
  output logic             pwm_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] prd_act;
  logic [CNT_W-1:0] cmp_act;
  logic             at_prd;
  logic             wrap;
  logic             load_phase;

  assign load_phase = sync_en_i && sync_in_i;   // R8: gated by enable

  pwmt_shadow #(.CNT_W(CNT_W)) shadow_i (
    .clk     (clk),
    .rst     (rst),
    .run     (run_i),
    .wrap    (wrap),
    .prd_in  (period_i),
    .cmp_in  (compare_i),
    .prd_act (prd_act),
    .cmp_act (cmp_act)
  );

  pwmt_timebase #(.CNT_W(CNT_W)) tb_i (
    .clk        (clk),
    .rst        (rst),
    .run        (run_i),
    .load_phase (load_phase),
    .phase      (phase_i),
    .prd_act    (prd_act),
    .cnt        (cnt_q),
    .at_prd     (at_prd),
    .wrap       (wrap)
  );

  pwmt_outstage #(.CNT_W(CNT_W)) out_i (
    .clk      (clk),
    .rst      (rst),
    .run      (run_i),
    .cnt      (cnt_q),
    .cmp_act  (cmp_act),
    .at_prd   (at_prd),
    .pol_low  (pol_low_i),
    .sync_sel (sync_sel_i),
    .sync_in  (sync_in_i),
    .pwm      (pwm_o),
    .sync_out (sync_out_o)
  );

endmodule

// File: rtl/phsync_pwm_checker.sv
module phsync_pwm_checker
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run_i,
  input logic             sync_en_i,
  input logic             sync_in_i,
  input logic [1:0]       sync_sel_i,
  input logic [CNT_W-1:0] phase_i,
  input logic             sync_out_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] prd_act,
  input logic [CNT_W-1:0] cmp_act
);

  logic ld;
  assign ld = sync_en_i && sync_in_i;

  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    (run_i && !ld && cnt_q >= prd_act) |=> (cnt_q == '0));

  a_r4_pulse: assert property (@(posedge clk) disable iff (rst)
    (sync_out_o && sync_sel_i == SYNC_PRD && prd_act != '0 && !$past(ld))
      |=> !sync_out_o);

  a_r5_relay: assert property (@(posedge clk) disable iff (rst)
    (sync_sel_i == SYNC_RELAY) |=> (sync_out_o == $past(sync_in_i)));

  a_r6_off: assert property (@(posedge clk) disable iff (rst)
    (sync_sel_i == SYNC_OFF || sync_sel_i == SYNC_OFF_B) |=> !sync_out_o);

  a_r7_load: assert property (@(posedge clk) disable iff (rst)
    (run_i && ld) |=> (cnt_q == $past(phase_i)));

  a_r8_step: assert property (@(posedge clk) disable iff (rst)
    (run_i && !ld && cnt_q < prd_act) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  a_r9_freeze: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> $stable(cnt_q));

  a_r9_no_pulse: assert property (@(posedge clk) disable iff (rst)
    (!run_i && sync_sel_i == SYNC_PRD) |=> !sync_out_o);

  a_r10_shadow: assert property (@(posedge clk) disable iff (rst)
    (run_i && cnt_q < prd_act) |=> ($stable(prd_act) && $stable(cmp_act)));

endmodule

bind phsync_pwm_timer phsync_pwm_checker #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .run_i      (run_i),
  .sync_en_i  (sync_en_i),
  .sync_in_i  (sync_in_i),
  .sync_sel_i (sync_sel_i),
  .phase_i    (phase_i),
  .sync_out_o (sync_out_o),
  .cnt_q      (cnt_q),
  .prd_act    (prd_act),
  .cmp_act    (cmp_act)
);

// File: tb/phsync_pwm_timer_tb_top.sv
`timescale 1ns/1ps
module phsync_pwm_timer_tb_top;

  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;   // 125 MHz

  logic         run  [3];
  logic [W-1:0] prd  [3];
  logic [W-1:0] cmp  [3];
  logic [W-1:0] ph   [3];
  logic         pol  [3];
  logic         sen  [3];
  logic [1:0]   ssel [3];
  logic         m_sin;
  logic         so   [3];
  logic         pw   [3];

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  phsync_pwm_timer #(.CNT_W(W)) dut_i (
    .clk(clk), .rst(rst), .run_i(run[0]), .period_i(prd[0]), .compare_i(cmp[0]),
    .phase_i(ph[0]), .pol_low_i(pol[0]), .sync_en_i(sen[0]), .sync_sel_i(ssel[0]),
    .sync_in_i(m_sin), .sync_out_o(so[0]), .pwm_o(pw[0]));

  phsync_pwm_timer #(.CNT_W(W)) slave_a_i (
    .clk(clk), .rst(rst), .run_i(run[1]), .period_i(prd[1]), .compare_i(cmp[1]),
    .phase_i(ph[1]), .pol_low_i(pol[1]), .sync_en_i(sen[1]), .sync_sel_i(ssel[1]),
    .sync_in_i(so[0]), .sync_out_o(so[1]), .pwm_o(pw[1]));

  phsync_pwm_timer #(.CNT_W(W)) slave_b_i (
    .clk(clk), .rst(rst), .run_i(run[2]), .period_i(prd[2]), .compare_i(cmp[2]),
    .phase_i(ph[2]), .pol_low_i(pol[2]), .sync_en_i(sen[2]), .sync_sel_i(ssel[2]),
    .sync_in_i(so[1]), .sync_out_o(so[2]), .pwm_o(pw[2]));

  // Rising-edge time stamps of each output, sampled at the falling edge
  int cyc = 0;
  int rise_at [3];
  logic pw_prev [3];
  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < 3; i++) begin
      if (pw[i] && !pw_prev[i]) rise_at[i] <= cyc;
      pw_prev[i] <= pw[i];
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Wait for a rising edge on the master output; returns clocks waited
  task automatic wait_rise(output int n);
    logic p;
    n = 0;
    p = pw[0];
    forever begin
      tick();
      n++;
      if (pw[0] && !p) break;
      p = pw[0];
      if (n > 300) begin
        check("R1", "no rising edge seen", 0, 1);
        break;
      end
    end
  endtask

  task automatic cfg(input int p, input int c, input logic pl,
                     input logic [1:0] sl, input logic se, input int f);
    run[0] = 1'b0;
    prd[0] = W'(p); cmp[0] = W'(c); pol[0] = pl;
    ssel[0] = sl; sen[0] = se; ph[0] = W'(f); m_sin = 1'b0;
    tick(); tick();
    run[0] = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    tick();
    check("R11", "pwm during reset", int'(pw[0]), 0);
    check("R11", "sync_out during reset", int'(so[0]), 0);
    rst = 1'b0;
  endtask

  task automatic t_duty();
    int n, highs;
    cfg(9, 3, 1'b0, 2'd0, 1'b0, 0);
    wait_rise(n);
    highs = int'(pw[0]);
    for (int k = 1; k < 10; k++) begin
      tick();
      highs += int'(pw[0]);
    end
    check("R2", "active-high clocks per cycle", highs, 3);
    check("R1", "low just before wrap", int'(pw[0]), 0);
    tick();
    check("R1", "rise after P+1 clocks", int'(pw[0]), 1);
  endtask

  task automatic t_polarity();
    int highs = 0;
    pol[0] = 1'b1;
    tick(); tick();
    for (int k = 0; k < 10; k++) begin
      tick();
      highs += int'(pw[0]);
    end
    check("R3", "active-low clocks per cycle", highs, 7);
    pol[0] = 1'b0;
  endtask

  task automatic t_bounds();
    int highs = 0;
    cfg(9, 0, 1'b0, 2'd0, 1'b0, 0);
    tick();
    for (int k = 0; k < 12; k++) begin
      tick();
      highs += int'(pw[0]);
    end
    check("R2", "compare 0 high clocks", highs, 0);
    cfg(9, 10, 1'b0, 2'd0, 1'b0, 0);
    tick();
    highs = 0;
    for (int k = 0; k < 12; k++) begin
      tick();
      highs += int'(pw[0]);
    end
    check("R2", "compare above period high clocks", highs, 12);
  endtask

  task automatic t_prd_pulse();
    int n, pulses = 0;
    int hi9 = 0, lo10 = 1;
    cfg(9, 3, 1'b0, 2'd1, 1'b0, 0);
    wait_rise(n);
    for (int k = 0; k < 20; k++) begin
      if (k > 0) tick();
      pulses += int'(so[0]);
      if (k == 9)  hi9  = int'(so[0]);
      if (k == 10) lo10 = int'(so[0]);
    end
    check("R4", "period pulses in two cycles", pulses, 2);
    check("R4", "pulse one clock before rise", hi9, 1);
    check("R4", "pulse is one clock wide", lo10, 0);
  endtask

  task automatic t_relay();
    ssel[0] = 2'd2;
    sen[0]  = 1'b0;
    tick(); tick();
    check("R5", "relay idle", int'(so[0]), 0);
    m_sin = 1'b1;
    tick();
    m_sin = 1'b0;
    check("R5", "relay one clock later", int'(so[0]), 1);
    tick();
    check("R5", "relay pulse ends", int'(so[0]), 0);
  endtask

  task automatic t_off();
    int seen = 0;
    for (int s = 0; s < 2; s++) begin
      ssel[0] = (s == 0) ? 2'd0 : 2'd3;
      for (int k = 0; k < 25; k++) begin
        m_sin = (k % 4 == 0);
        tick();
        if (k > 0) seen += int'(so[0]);
      end
    end
    m_sin = 1'b0;
    check("R6", "sync_out with select 0 and 3", seen, 0);
  endtask

  task automatic t_load();
    int n;
    cfg(9, 5, 1'b0, 2'd0, 1'b1, 7);
    wait_rise(n);
    m_sin = 1'b1;
    tick();
    m_sin = 1'b0;
    tick();
    check("R7", "output low after phase load", int'(pw[0]), 0);
    tick(); tick(); tick();
    check("R7", "rise after loaded counter wraps", int'(pw[0]), 1);
  endtask

  task automatic t_ignore();
    int n;
    cfg(9, 5, 1'b0, 2'd0, 1'b0, 7);
    wait_rise(n);
    m_sin = 1'b1;
    tick();
    m_sin = 1'b0;
    tick();
    check("R8", "disabled sync leaves output high", int'(pw[0]), 1);
    tick(); tick(); tick();
    check("R8", "normal fall at compare", int'(pw[0]), 0);
  endtask

  task automatic t_stop();
    int n, held, changed = 0, pulses = 0;
    cfg(9, 5, 1'b0, 2'd1, 1'b0, 0);
    tick(); tick(); tick();
    run[0] = 1'b0;
    tick();
    held = int'(pw[0]);
    for (int k = 0; k < 25; k++) begin
      tick();
      if (int'(pw[0]) != held) changed++;
      pulses += int'(so[0]);
    end
    check("R9", "output changes while stopped", changed, 0);
    check("R9", "period pulses while stopped", pulses, 0);
    run[0] = 1'b1;
    wait_rise(n);
    check("R9", "resumes within one cycle", int'(n <= 11), 1);
  endtask

  task automatic t_shadow();
    int n;
    cfg(9, 5, 1'b0, 2'd0, 1'b0, 0);
    wait_rise(n);
    cmp[0] = W'(2);
    tick(); tick(); tick();
    check("R10", "old compare kept mid-cycle", int'(pw[0]), 1);
    for (int k = 3; k < 11; k++) tick();
    check("R10", "new compare after wrap (high)", int'(pw[0]), 1);
    tick();
    check("R10", "new compare after wrap (low)", int'(pw[0]), 0);
    prd[0] = W'(4);
    wait_rise(n);
    wait_rise(n);
    check("R10", "new period length", n, 5);
  endtask

  task automatic t_chain();
    int o1, o2;
    for (int i = 0; i < 3; i++) begin
      run[i] = 1'b0; prd[i] = W'(11); cmp[i] = W'(6); pol[i] = 1'b0;
    end
    sen[0] = 1'b0; ph[0] = W'(0); ssel[0] = 2'd1;
    sen[1] = 1'b1; ph[1] = W'(9); ssel[1] = 2'd2;
    sen[2] = 1'b1; ph[2] = W'(6); ssel[2] = 2'd0;
    m_sin = 1'b0;
    tick(); tick();
    for (int i = 0; i < 3; i++) run[i] = 1'b1;
    for (int k = 0; k < 60; k++) tick();
    o1 = (((rise_at[1] - rise_at[0]) % 12) + 12) % 12;
    o2 = (((rise_at[2] - rise_at[0]) % 12) + 12) % 12;
    check("R12", "first follower offset", o1, 4);
    check("R12", "second follower offset", o2, 8);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      run[i] = 1'b0; prd[i] = '0; cmp[i] = '0; ph[i] = '0;
      pol[i] = 1'b0; sen[i] = 1'b0; ssel[i] = 2'd0; pw_prev[i] = 1'b0;
      rise_at[i] = 0;
    end
    m_sin = 1'b0;
    repeat (3) @(posedge clk);
    t_reset();
    t_duty();
    t_polarity();
    t_bounds();
    t_prd_pulse();
    t_relay();
    t_off();
    t_load();
    t_ignore();
    t_stop();
    t_shadow();
    t_chain();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule